// File: doc/BRIEF.md
# SPI Master Transaction Sequencer

This block is the control state machine on the master side of a serial peripheral port. Once a start command arrives, it asserts up to four chip-select lines and waits a programmable lead-in time before the bit shifter may clock. It counts the characters that the shifter reports as finished, then waits a programmable tail time. After the tail time it either releases select or keeps it asserted.

When a transaction ends while the transmit FIFO still holds data, the sequencer chains straight into the next transaction. Between two such transactions it keeps select inactive for a programmable gap, unless the hold option keeps select asserted throughout. Each of the three delays is an 8-bit count of system clocks, and a programmed 0 means 256 clocks.

A bit shifter elsewhere does the shifting. It sees `shift_en_o` and answers with one `char_done_i` pulse per character. A start bit that clears itself, a busy flag and three one-cycle events (done, select rose, select fell) report progress.

Top module: `spi_master_seq`

## Requirements
- R1: After reset, busy, start bit, shift enable and all events are 0. Every select pin sits at its inactive level, which is the inverse of its polarity bit.
- R2: A start pulse sets the start bit on the next edge. When either character count is non-zero, one edge later busy rises and select asserts. Busy implies the start bit is set.
- R3: The first cycle with shift enable high comes exactly N cycles after select asserts, where N is the lead-in value (0 means 256).
- R4: A transaction shifts max(tx count, rx count) characters. Shift enable falls on the edge after the last `char_done_i` pulse, and shift enable is never high while select is inactive.
- R5: Without hold, select deasserts M+1 cycles after the last shift-enable cycle, where M is the tail value (0 means 256).
- R6: If `tx_empty_i` is 0 when the tail time ends, a new transaction follows. Without hold, select stays inactive for exactly G cycles, where G is the gap value (0 means 256), and then reasserts.
- R7: With hold set, select stays asserted across chained transactions, and the next transaction's lead-in starts right after the tail. Select stays asserted in idle and drops on the edge after hold is cleared.
- R8: Select pin i is driven to polarity bit i while selection is active and mask bit i is set. Otherwise pin i is driven to the inverse of polarity bit i.
- R9: Done pulses for exactly one cycle, once per start command, on the edge where the sequencer returns to idle. Start bit and busy are 0 from that edge on.
- R10: With both counts zero, a start command ends two edges after the start pulse with a done pulse. There is no select activity, and busy never rises.
- R11: The select-asserted and select-deasserted events pulse for one cycle in the cycle where selection becomes active or inactive.
- R12: A start pulse while busy has no effect: exactly one done pulse and one run of transactions result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start command pulse (sets the start bit) |
| hold_sel_i | input | 1 | 1: leave select asserted at the end of a transaction |
| sel_mask_i | input | 4 | Which select lines take part |
| sel_pol_i | input | 4 | Per-line active level (1 = active high) |
| lead_dly_i | input | 8 | Clocks from select assertion to first shift cycle (0 = 256) |
| tail_dly_i | input | 8 | Clocks from last shift cycle to select release (0 = 256) |
| gap_dly_i | input | 8 | Inactive clocks between chained transactions (0 = 256) |
| tx_chars_i | input | 16 | Characters to transmit per transaction |
| rx_chars_i | input | 16 | Characters to receive per transaction |
| tx_empty_i | input | 1 | Transmit FIFO empty flag |
| char_done_i | input | 1 | Shifter finished one character |
| shift_en_o | output | 1 | Shifter may run |
| sel_o | output | 4 | Chip-select pins |
| start_o | output | 1 | Start bit (self-clearing) |
| busy_o | output | 1 | Transaction sequence in progress |
| done_o | output | 1 | One-cycle pulse at the end of the last chained transaction |
| sel_rise_o | output | 1 | One-cycle pulse when selection becomes active |
| sel_fall_o | output | 1 | One-cycle pulse when selection becomes inactive |

## Verification
The embedded assertions check, on every cycle, the local rules of the sequencer. Shifting happens only under an active select, done is a single-cycle pulse that leaves busy and the start bit clear, and the edge events line up with the internal select state. The delay counter steps down by one per cycle, and a zero-count start produces no select edge. The exact delay lengths are left to the bench's reference model and its measured scenarios. So are the 256-clock meaning of zero, the character count of max(tx, rx), chaining with and without hold, polarity and masking per pin, and the ignored start while busy.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TAIL,
        ST_GAP
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       start;
        logic       sel;
        logic       done;
        logic       rise;
        logic       fall;
    } seq_regs_t;

endpackage

// File: rtl/spi_seq_delay.sv
module spi_seq_delay #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DLY_W-1:0] value_i,
    output logic             zero_o
);
    logic [DLY_W-1:0] cnt_d, cnt_q;

    // value 0 wraps to all ones: 2**DLY_W cycles
    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = value_i - 1'b1;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    p_dly_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/spi_seq_chars.sv
module spi_seq_chars #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i)     cnt_d = '0;
        else if (step_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = step_i && (({1'b0, cnt_q} + 1'b1) == {1'b0, len_i});

    p_chars_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0));

endmodule

// File: rtl/spi_seq_select.sv
module spi_seq_select #(
    parameter int NUM_SEL = 4
) (
    input  logic               active_i,
    input  logic [NUM_SEL-1:0] mask_i,
    input  logic [NUM_SEL-1:0] pol_i,
    output logic [NUM_SEL-1:0] pins_o
);
    for (genvar i = 0; i < NUM_SEL; i++) begin : g_pin
        assign pins_o[i] = (active_i && mask_i[i]) ? pol_i[i] : ~pol_i[i];
    end

endmodule

// File: rtl/spi_master_seq.sv
module spi_master_seq
    import spi_seq_pkg::*;
#(
    parameter int NUM_SEL = 4,
    parameter int DLY_W   = 8,
    parameter int CNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               hold_sel_i,
    input  logic [NUM_SEL-1:0] sel_mask_i,
    input  logic [NUM_SEL-1:0] sel_pol_i,
    input  logic [DLY_W-1:0]   lead_dly_i,
    input  logic [DLY_W-1:0]   tail_dly_i,
    input  logic [DLY_W-1:0]   gap_dly_i,
    input  logic [CNT_W-1:0]   tx_chars_i,
    input  logic [CNT_W-1:0]   rx_chars_i,
    input  logic               tx_empty_i,
    input  logic               char_done_i,
    output logic               shift_en_o,
    output logic [NUM_SEL-1:0] sel_o,
    output logic               start_o,
    output logic               busy_o,
    output logic               done_o,
    output logic               sel_rise_o,
    output logic               sel_fall_o
);
    seq_regs_t        r_d, r_q;
    logic [CNT_W-1:0] len;
    logic             len_zero;
    logic             dly_load, dly_zero;
    logic [DLY_W-1:0] dly_val;
    logic             chr_clear, chr_step, chr_last;

    assign len      = (tx_chars_i > rx_chars_i) ? tx_chars_i : rx_chars_i;
    assign len_zero = (len == '0);
    assign chr_step = char_done_i && (r_q.state == ST_SHIFT);

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.start = r_q.start | start_i;
        dly_load  = 1'b0;
        dly_val   = lead_dly_i;
        chr_clear = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                chr_clear = 1'b1;
                if (r_q.start) begin
                    if (len_zero) begin
                        r_d.start = 1'b0;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.state = ST_LEAD;
                        r_d.sel   = 1'b1;
                        dly_load  = 1'b1;
                    end
                end else begin
                    r_d.sel = r_q.sel & hold_sel_i;
                end
            end
            ST_LEAD: begin
                if (dly_zero) r_d.state = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (chr_last) begin
                    r_d.state = ST_TAIL;
                    dly_load  = 1'b1;
                    dly_val   = tail_dly_i;
                    chr_clear = 1'b1;
                end
            end
            ST_TAIL: begin
                if (dly_zero) begin
                    if (!hold_sel_i) r_d.sel = 1'b0;
                    if (!tx_empty_i) begin
                        dly_load = 1'b1;
                        if (hold_sel_i) begin
                            r_d.state = ST_LEAD;
                        end else begin
                            r_d.state = ST_GAP;
                            dly_val   = gap_dly_i;
                        end
                    end else begin
                        r_d.state = ST_IDLE;
                        r_d.start = 1'b0;
                        r_d.done  = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (dly_zero) begin
                    r_d.state = ST_LEAD;
                    r_d.sel   = 1'b1;
                    dly_load  = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
        r_d.rise = r_d.sel & ~r_q.sel;
        r_d.fall = ~r_d.sel & r_q.sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    spi_seq_delay #(.DLY_W(DLY_W)) i_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (dly_load),
        .value_i (dly_val),
        .zero_o  (dly_zero)
    );

    spi_seq_chars #(.CNT_W(CNT_W)) i_chars (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (chr_clear),
        .step_i  (chr_step),
        .len_i   (len),
        .last_o  (chr_last)
    );

    spi_seq_select #(.NUM_SEL(NUM_SEL)) i_select (
        .active_i (r_q.sel),
        .mask_i   (sel_mask_i),
        .pol_i    (sel_pol_i),
        .pins_o   (sel_o)
    );

    assign shift_en_o = (r_q.state == ST_SHIFT);
    assign busy_o     = (r_q.state != ST_IDLE);
    assign start_o    = r_q.start;
    assign done_o     = r_q.done;
    assign sel_rise_o = r_q.rise;
    assign sel_fall_o = r_q.fall;

    p_shift_needs_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en_o |-> r_q.sel);

    p_busy_has_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> start_o);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !start_o));

    p_rise_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sel_rise_o |-> (r_q.sel && !$past(r_q.sel)));

    p_fall_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sel_fall_o |-> (!r_q.sel && $past(r_q.sel)));

    p_zero_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && r_q.start && len_zero && !r_q.sel) |=> !sel_rise_o);

endmodule

// File: tb/test_spi_master_seq.sv
module test_spi_master_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, hold_sel_i = 1'b0;
    logic [3:0]  sel_mask_i = 4'b0001, sel_pol_i = 4'b0000;
    logic [7:0]  lead_dly_i = 8'd3, tail_dly_i = 8'd2, gap_dly_i = 8'd4;
    logic [15:0] tx_chars_i = 16'd2, rx_chars_i = 16'd1;
    logic        tx_empty_i = 1'b1, char_done_i = 1'b0;
    logic        shift_en_o, start_o, busy_o, done_o, sel_rise_o, sel_fall_o;
    logic [3:0]  sel_o;

    always #10 clk = ~clk;

    spi_master_seq i_spi_master_seq (.*);

    int n_tests = 0, n_fail = 0;
    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int nz(input logic [7:0] v);
        return (v == 0) ? 256 : int'(v);
    endfunction

    // reference model, updated on each rising edge
    int m_phase = 0, m_timer = 0, m_chars = 0;
    bit m_sel = 0, m_start = 0, m_done = 0, m_rise = 0, m_fall = 0;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_timer = 0; m_chars = 0;
            m_sel = 0; m_start = 0; m_done = 0; m_rise = 0; m_fall = 0;
        end else begin
            automatic bit old_sel = m_sel;
            automatic bit old_start = m_start;
            automatic int len = (tx_chars_i > rx_chars_i) ? tx_chars_i : rx_chars_i;
            m_done = 0;
            m_start = m_start | start_i;
            case (m_phase)
                0: if (old_start) begin
                       if (len == 0) begin m_start = 0; m_done = 1; end
                       else begin m_phase = 1; m_timer = nz(lead_dly_i); m_sel = 1; end
                   end else m_sel = m_sel & hold_sel_i;
                1: if (m_timer == 1) m_phase = 2; else m_timer--;
                2: if (char_done_i) begin
                       m_chars++;
                       if (m_chars == len) begin m_phase = 3; m_timer = nz(tail_dly_i); m_chars = 0; end
                   end
                3: if (m_timer == 1) begin
                       if (!hold_sel_i) m_sel = 0;
                       if (!tx_empty_i) begin
                           if (hold_sel_i) begin m_phase = 1; m_timer = nz(lead_dly_i); end
                           else begin m_phase = 4; m_timer = nz(gap_dly_i); end
                       end else begin m_phase = 0; m_start = 0; m_done = 1; end
                   end else m_timer--;
                default: if (m_timer == 1) begin m_phase = 1; m_timer = nz(lead_dly_i); m_sel = 1; end
                         else m_timer--;
            endcase
            m_rise = m_sel & !old_sel;
            m_fall = !m_sel & old_sel;
        end
    end

    // monitor: compare every cycle, record event timing
    int cyc = 0, n_rise = 0, n_fall = 0, n_done = 0, n_shift_up = 0, n_pulses = 0;
    int t_rise = 0, t_fall = 0, t_first_shift = 0, t_last_shift = 0, gap_meas = -1, inter_shift = -1;
    bit prev_shift = 0, busy_seen = 0, sc_busy = 0;
    int sc = 0;
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
        if (rst_n) begin
            automatic logic [3:0] exp_sel;
            for (int i = 0; i < 4; i++) exp_sel[i] = (m_sel && sel_mask_i[i]) ? sel_pol_i[i] : !sel_pol_i[i];
            chk(sel_o == exp_sel, "R8 sel pins", sel_o, exp_sel);
            chk(busy_o == (m_phase != 0), "R2 busy", busy_o, m_phase != 0);
            chk(start_o == m_start, "R9 start bit", start_o, m_start);
            chk(done_o == m_done, "R9 done", done_o, m_done);
            chk(sel_rise_o == m_rise && sel_fall_o == m_fall, "R11 events",
                {sel_rise_o, sel_fall_o}, {m_rise, m_fall});
            chk(shift_en_o == (m_phase == 2), "R4 shift enable", shift_en_o, m_phase == 2);
            if (busy_o) busy_seen = 1;
            if (sel_rise_o) begin n_rise++; gap_meas = cyc - t_fall; t_rise = cyc; end
            if (sel_fall_o) begin n_fall++; t_fall = cyc; end
            if (done_o) n_done++;
            if (shift_en_o && !prev_shift) begin
                n_shift_up++; inter_shift = cyc - t_last_shift; t_first_shift = cyc;
            end
            if (shift_en_o) t_last_shift = cyc;
            prev_shift = shift_en_o;
        end
        // behavioural shifter: one character every 3 enabled cycles
        if (char_done_i) char_done_i <= 1'b0;
        else if (shift_en_o) begin
            sc++;
            if (sc == 3) begin char_done_i <= 1'b1; sc = 0; n_pulses++; end
        end
    end

    task automatic clear_stats();
        n_rise = 0; n_fall = 0; n_done = 0; n_shift_up = 0; n_pulses = 0;
        busy_seen = 0; gap_meas = -1; inter_shift = -1; sc = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic wait_done();
        while (n_done == 0) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy_o == 0 && start_o == 0 && done_o == 0 && shift_en_o == 0, "R1 reset flags",
            {busy_o, start_o, done_o, shift_en_o}, 0);
        chk(sel_o == 4'b1111, "R1 reset select level", sel_o, 4'b1111);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // basic transaction, plus start while busy (R12)
        clear_stats();
        pulse_start();
        chk(start_o == 1, "R2 start bit set", start_o, 1);
        @(negedge clk);
        chk(busy_o == 1 && sel_o == 4'b1110, "R2 busy and select", {busy_o, sel_o}, {1'b1, 4'b1110});
        pulse_start();
        wait_done();
        chk(t_first_shift - t_rise == 3, "R3 lead delay", t_first_shift - t_rise, 3);
        chk(n_pulses == 2, "R4 char count max(tx,rx)", n_pulses, 2);
        chk(t_fall - t_last_shift == 3, "R5 tail delay", t_fall - t_last_shift, 3);
        repeat (20) @(negedge clk);
        chk(n_done == 1 && n_rise == 1, "R12 start while busy ignored", n_done, 1);
        chk(start_o == 0 && busy_o == 0, "R9 start bit cleared", {start_o, busy_o}, 0);

        // lead 0 = 256, rx larger, polarity and mask
        clear_stats();
        lead_dly_i = 8'd0; tail_dly_i = 8'd0; tx_chars_i = 16'd1; rx_chars_i = 16'd3;
        sel_mask_i = 4'b1110; sel_pol_i = 4'b1010;
        pulse_start();
        @(negedge clk);
        chk(sel_o == 4'b1011, "R8 polarity and mask active", sel_o, 4'b1011);
        wait_done();
        chk(t_first_shift - t_rise == 256, "R3 lead zero means 256", t_first_shift - t_rise, 256);
        chk(t_fall - t_last_shift == 257, "R5 tail zero means 256", t_fall - t_last_shift, 257);
        chk(n_pulses == 3, "R4 char count rx larger", n_pulses, 3);
        chk(sel_o == 4'b0101, "R8 inactive levels", sel_o, 4'b0101);

        // chained transactions without hold
        clear_stats();
        lead_dly_i = 8'd2; tail_dly_i = 8'd1; gap_dly_i = 8'd5; tx_chars_i = 16'd1; rx_chars_i = 16'd1;
        sel_mask_i = 4'b0011; sel_pol_i = 4'b0000; tx_empty_i = 1'b0;
        pulse_start();
        while (n_shift_up < 2) @(negedge clk);
        tx_empty_i = 1'b1;
        wait_done();
        chk(gap_meas == 5, "R6 gap between chained transactions", gap_meas, 5);
        chk(n_rise == 2 && n_fall == 2, "R6 two transactions", n_rise, 2);
        chk(n_done == 1, "R9 one done per chain", n_done, 1);

        // chained with hold
        clear_stats();
        hold_sel_i = 1'b1; tx_empty_i = 1'b0; tail_dly_i = 8'd3;
        pulse_start();
        while (n_shift_up < 2) @(negedge clk);
        tx_empty_i = 1'b1;
        wait_done();
        chk(n_rise == 1 && n_fall == 0, "R7 select held across chain", {n_rise, n_fall}, 1 << 32);
        chk(inter_shift == 3 + 2 + 1, "R7 lead follows tail directly", inter_shift, 6);
        repeat (5) @(negedge clk);
        chk(sel_o == 4'b1100, "R7 select held in idle", sel_o, 4'b1100);
        hold_sel_i = 1'b0;
        @(negedge clk);
        chk(sel_fall_o == 1 && sel_o == 4'b1111, "R7 release on hold clear", {sel_fall_o, sel_o}, 5'b11111);

        // zero character counts
        repeat (3) @(negedge clk);
        clear_stats();
        tx_chars_i = 16'd0; rx_chars_i = 16'd0;
        pulse_start();
        @(negedge clk);
        chk(done_o == 1 && start_o == 0, "R10 zero counts finish", {done_o, start_o}, 2'b10);
        repeat (5) @(negedge clk);
        chk(n_rise == 0 && busy_seen == 0, "R10 no select activity", {n_rise, busy_seen}, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule